// File: doc/BRIEF.md
# Flash Byte Program Sequencer with Read-Back Verify

This block writes a run of bytes into a byte-wide flash device that takes command writes. It never lets a run leave the 64 KiB erase block in which it starts. A start pulse brings in a start address and a requested byte count. The block trims the count where the run meets the end of the block. Each byte is then programmed in a fixed bus sequence:

1. a dummy read,
2. a pulse that opens the external write gate,
3. a byte-lane select,
4. the program opcode and then the data,
5. a status request,
6. status polling,
7. a return to array-read mode.

The data arrives on a ready/valid byte stream, and the source presents the run twice. The first presentation feeds programming. The second feeds a read-back comparison that starts after a settling pause.

Two retry policies apply. A status poll that never reports ready is cleared, and the same byte is tried again at once. A program failure reported in the status byte is cleared, and the same byte is tried again after a wait, as long as the overall time budget for the run has not run out. When the budget has run out, the run ends with -2.

The run ends with a one-cycle `done` and a signed result:
- the trimmed count on success,
- 0 on the first read-back difference,
- -2 when the budget is exhausted.

When a run ends early, the block first accepts and discards the stream beats that are still outstanding. All time limits are parameters counted in clock cycles.

Top module: `fbp_seq`

## Requirements
- R1: A start with a byte count of 0 raises `done` in the next cycle with result 0. That run makes no flash access and accepts no stream beat.
- R2: The effective count is the requested count. If the in-block offset (`start_addr[BLK_W-1:0]`) plus the count exceeds 2^BLK_W, the effective count is 2^BLK_W minus the offset instead. Exactly twice the effective count of stream beats is accepted, and only addresses inside the run are programmed.
- R3: Each attempt for a byte runs in this order:
  - a read at offset 0x8000;
  - one `gate_pulse`;
  - `lane_we` with `lane_sel` equal to the byte address bits 1..0;
  - a write of 0x40 and then a write of the data byte, both to the byte address with bits 1..0 cleared;
  - a write of 0x70 to offset 0x10000;
  - reads at offset 0x8000 until `fl_rdata` bit 7 is 1;
  - one `gate_pulse`;
  - a write of 0xFF to offset 0x8000.

  No cycle both reads and writes.
- R4: Status polls are counted from 0. If status is not ready on poll number POLL_LIMIT, the block gives one `gate_pulse`, writes 0x50 to offset 0x8000, and restarts the same byte at its dummy read. Ready on or before that poll is accepted without a retry.
- R5: If bit 4 of the ready status byte is 1, and the budget is not spent, the block gives one `gate_pulse`, writes 0x50 to offset 0x8000, waits RETRY_WAIT cycles, and programs the same byte again.
- R6: The budget counts the cycles since start. A program failure seen once BUDGET_LIMIT cycles have elapsed ends the run with result -2.
- R7: After the last byte has been programmed, the block pauses SETTLE_WAIT cycles. It then accepts one beat per byte, reads the byte address, and compares the two. If every byte matches, the result is the effective count.
- R8: The first read-back byte that differs from its beat ends the run with result 0.
- R9: `done` is high for exactly one cycle, and `result` holds its value until the next run ends.
- R10: After a -2 or a read-back difference, beats are accepted and dropped until twice the effective count has been taken. Only then does `done` rise. `s_ready` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken while idle) |
| start_addr | input | ADDR_W | Device byte address of the first byte |
| byte_cnt | input | CNT_W | Requested byte count |
| s_valid | input | 1 | Stream beat valid |
| s_data | input | 8 | Stream beat byte |
| s_ready | output | 1 | Stream beat accepted this cycle when valid |
| fl_addr | output | ADDR_W | Flash device address |
| fl_wdata | output | 8 | Flash write byte |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 8 | Flash read byte, valid in the cycle of `fl_re` |
| gate_pulse | output | 1 | Opens the external write gate |
| lane_we | output | 1 | Loads the byte-lane register |
| lane_sel | output | 2 | Byte-lane value |
| done | output | 1 | Run finished (one cycle) |
| result | output | BLK_W+2 | Signed result: count, 0, or -2 |

## Verification
The bench builds the block with these values:

| Parameter | Value |
|---|---|
| POLL_LIMIT | 6 |
| RETRY_WAIT | 5 |
| SETTLE_WAIT | 4 |
| BUDGET_LIMIT | 400 |
| ADDR_W | 20 |
| BLK_W | 16 |

The short limits put a poll timeout, a delayed retry and a spent budget within a few hundred cycles. With a 64 KiB block, runs that start a few bytes below a block boundary exercise trimming by small counts, and so does an oversized count. A model of the flash counts program operations and clear commands. The bench compares these counts with the number of retries each requirement implies. It also sets the status delay exactly at the poll limit, to separate an accepted late status from a timeout.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

  typedef enum logic [4:0] {
    ST_IDLE, ST_FETCH, ST_DUMMY, ST_GATE, ST_LANE, ST_CMD, ST_DATA, ST_SREQ,
    ST_POLL, ST_TGATE, ST_TCLR, ST_RGATE, ST_RMODE, ST_EGATE, ST_ECLR,
    ST_RWAIT, ST_SETTLE, ST_VFETCH, ST_VREAD, ST_DRAIN, ST_DONE
  } fbp_state_e;

  localparam logic [7:0] OP_PROGRAM = 8'h40;
  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_CLEAR   = 8'h50;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

  localparam int STAT_READY_BIT = 7;
  localparam int STAT_FAIL_BIT  = 4;

endpackage

// File: rtl/fbp_timer.sv
// Saturating cycle counter: expired once LIMIT ticks have been counted since clr.
module fbp_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/fbp_clip.sv
// Trims a requested count so that the run ends at the block boundary.
module fbp_clip #(
  parameter int CNT_W = 20,
  parameter int BLK_W = 16
) (
  input  logic [BLK_W-1:0] offset,
  input  logic [CNT_W-1:0] req_cnt,
  output logic [BLK_W:0]   eff_cnt
);
  localparam int SW = ((CNT_W > BLK_W + 1) ? CNT_W : BLK_W + 1) + 1;

  function automatic logic [BLK_W:0] trim_to_block(logic [BLK_W-1:0] off,
                                                   logic [CNT_W-1:0] n);
    logic [SW-1:0] room;
    logic [SW-1:0] want;
    room = (SW'(1) << BLK_W) - SW'(off);
    want = SW'(n);
    return (want > room) ? room[BLK_W:0] : want[BLK_W:0];
  endfunction

  assign eff_cnt = trim_to_block(offset, req_cnt);
endmodule

// File: rtl/fbp_seq.sv
module fbp_seq
  import fbp_pkg::*;
#(
  parameter int          ADDR_W       = 22,
  parameter int          CNT_W        = 20,
  parameter int          BLK_W        = 16,
  parameter int unsigned POLL_LIMIT   = 50_000_000,
  parameter int unsigned RETRY_WAIT   = 500_000,
  parameter int unsigned SETTLE_WAIT  = 500_000,
  parameter int unsigned BUDGET_LIMIT = 1_500_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       start_addr,
  input  logic [CNT_W-1:0]        byte_cnt,
  input  logic                    s_valid,
  input  logic [7:0]              s_data,
  output logic                    s_ready,
  output logic [ADDR_W-1:0]       fl_addr,
  output logic [7:0]              fl_wdata,
  output logic                    fl_we,
  output logic                    fl_re,
  input  logic [7:0]              fl_rdata,
  output logic                    gate_pulse,
  output logic                    lane_we,
  output logic [1:0]              lane_sel,
  output logic                    done,
  output logic signed [BLK_W+1:0] result
);
  localparam int EFF_W  = BLK_W + 1;
  localparam int BEAT_W = BLK_W + 2;
  localparam int RES_W  = BLK_W + 2;
  localparam logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'(32'h0000_8000);
  localparam logic [ADDR_W-1:0] STREQ_OFS = ADDR_W'(32'h0001_0000);
  localparam logic signed [RES_W-1:0] RES_TIMEOUT = RES_W'(-2);

  function automatic logic [ADDR_W-1:0] word_of(logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction

  function automatic logic signed [RES_W-1:0] count_result(logic [EFF_W-1:0] n);
    return $signed({1'b0, n});
  endfunction

  fbp_state_e        st;
  logic [ADDR_W-1:0] base_q;
  logic [EFF_W-1:0]  eff_q;
  logic [EFF_W-1:0]  idx_q;
  logic [BEAT_W-1:0] beats_q;
  logic [7:0]        data_q;
  logic              fail_q;
  logic signed [RES_W-1:0] res_q;

  logic [EFF_W-1:0]  eff_w;
  logic [ADDR_W-1:0] byte_addr;
  logic              last_byte;
  logic              all_beats;
  logic              poll_exp, rwait_exp, settle_exp, budget_exp;

  // Named internal events, also watched by the checker.
  logic ev_start, ev_poll_ready, ev_poll_tmo, ev_budget_out, ev_mismatch, ev_cmd;

  fbp_clip #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_clip (
    .offset (start_addr[BLK_W-1:0]),
    .req_cnt(byte_cnt),
    .eff_cnt(eff_w)
  );

  fbp_timer #(.LIMIT(POLL_LIMIT)) u_poll_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_SREQ),
    .tick(st == ST_POLL), .expired(poll_exp));

  fbp_timer #(.LIMIT(RETRY_WAIT)) u_rwait_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_ECLR),
    .tick(st == ST_RWAIT), .expired(rwait_exp));

  fbp_timer #(.LIMIT(SETTLE_WAIT)) u_settle_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_RMODE),
    .tick(st == ST_SETTLE), .expired(settle_exp));

  fbp_timer #(.LIMIT(BUDGET_LIMIT)) u_budget_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st == ST_IDLE),
    .tick(st != ST_IDLE), .expired(budget_exp));

  assign byte_addr = base_q + ADDR_W'(idx_q);
  assign last_byte = ((idx_q + 1'b1) == eff_q);
  assign all_beats = (beats_q == {eff_q, 1'b0});

  assign ev_start      = (st == ST_IDLE) && start;
  assign ev_poll_ready = (st == ST_POLL) && fl_rdata[STAT_READY_BIT];
  assign ev_poll_tmo   = (st == ST_POLL) && !fl_rdata[STAT_READY_BIT] && poll_exp;
  assign ev_budget_out = (st == ST_ECLR) && budget_exp;
  assign ev_mismatch   = (st == ST_VREAD) && (fl_rdata != data_q);
  assign ev_cmd        = (st == ST_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      base_q  <= '0;
      eff_q   <= '0;
      idx_q   <= '0;
      beats_q <= '0;
      data_q  <= '0;
      fail_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          base_q  <= start_addr;
          eff_q   <= eff_w;
          idx_q   <= '0;
          beats_q <= '0;
          if (eff_w == '0) begin
            res_q <= '0;
            st    <= ST_DONE;
          end else begin
            st <= ST_FETCH;
          end
        end
        ST_FETCH: if (s_valid) begin
          data_q  <= s_data;
          beats_q <= beats_q + 1'b1;
          st      <= ST_DUMMY;
        end
        ST_DUMMY: st <= ST_GATE;
        ST_GATE:  st <= ST_LANE;
        ST_LANE:  st <= ST_CMD;
        ST_CMD:   st <= ST_DATA;
        ST_DATA:  st <= ST_SREQ;
        ST_SREQ:  st <= ST_POLL;
        ST_POLL: begin
          if (ev_poll_ready) begin
            fail_q <= fl_rdata[STAT_FAIL_BIT];
            st     <= ST_RGATE;
          end else if (poll_exp) begin
            st <= ST_TGATE;
          end
        end
        ST_TGATE: st <= ST_TCLR;
        ST_TCLR:  st <= ST_DUMMY;
        ST_RGATE: st <= ST_RMODE;
        ST_RMODE: begin
          if (fail_q) begin
            st <= ST_EGATE;
          end else if (last_byte) begin
            idx_q <= '0;
            st    <= ST_SETTLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= ST_FETCH;
          end
        end
        ST_EGATE: st <= ST_ECLR;
        ST_ECLR: begin
          if (budget_exp) begin
            res_q <= RES_TIMEOUT;
            st    <= ST_DRAIN;
          end else begin
            st <= ST_RWAIT;
          end
        end
        ST_RWAIT:  if (rwait_exp) st <= ST_DUMMY;
        ST_SETTLE: if (settle_exp) st <= ST_VFETCH;
        ST_VFETCH: if (s_valid) begin
          data_q  <= s_data;
          beats_q <= beats_q + 1'b1;
          st      <= ST_VREAD;
        end
        ST_VREAD: begin
          if (ev_mismatch) begin
            res_q <= '0;
            st    <= ST_DRAIN;
          end else if (last_byte) begin
            res_q <= count_result(eff_q);
            st    <= ST_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st    <= ST_VFETCH;
          end
        end
        ST_DRAIN: begin
          if (all_beats)    st <= ST_DONE;
          else if (s_valid) beats_q <= beats_q + 1'b1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_addr  = '0;
    fl_wdata = '0;
    unique case (st)
      ST_DUMMY, ST_POLL: fl_addr = STAT_OFS;
      ST_CMD: begin
        fl_addr  = word_of(byte_addr);
        fl_wdata = OP_PROGRAM;
      end
      ST_DATA: begin
        fl_addr  = word_of(byte_addr);
        fl_wdata = data_q;
      end
      ST_SREQ: begin
        fl_addr  = STREQ_OFS;
        fl_wdata = OP_STATUS;
      end
      ST_TCLR, ST_ECLR: begin
        fl_addr  = STAT_OFS;
        fl_wdata = OP_CLEAR;
      end
      ST_RMODE: begin
        fl_addr  = STAT_OFS;
        fl_wdata = OP_ARRAY;
      end
      ST_VREAD: fl_addr = byte_addr;
      default: ;
    endcase
  end

  assign fl_re      = (st == ST_DUMMY) || (st == ST_POLL) || (st == ST_VREAD);
  assign fl_we      = (st == ST_CMD) || (st == ST_DATA) || (st == ST_SREQ) ||
                      (st == ST_TCLR) || (st == ST_RMODE) || (st == ST_ECLR);
  assign gate_pulse = (st == ST_GATE) || (st == ST_TGATE) ||
                      (st == ST_RGATE) || (st == ST_EGATE);
  assign lane_we    = (st == ST_LANE);
  assign lane_sel   = byte_addr[1:0];
  assign s_ready    = (st == ST_FETCH) || (st == ST_VFETCH) ||
                      ((st == ST_DRAIN) && !all_beats);
  assign done       = (st == ST_DONE);
  assign result     = res_q;

endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
  parameter int EFF_W = 17,
  parameter int RES_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ev_start,
  input logic [EFF_W-1:0]        eff,
  input logic                    ev_poll_tmo,
  input logic                    ev_budget_out,
  input logic                    ev_mismatch,
  input logic                    ev_cmd,
  input logic                    fl_we,
  input logic                    fl_re,
  input logic [7:0]              fl_wdata,
  input logic                    gate_pulse,
  input logic                    lane_we,
  input logic                    s_ready,
  input logic                    done,
  input logic signed [RES_W-1:0] result
);
  localparam logic signed [RES_W-1:0] MINUS_TWO = RES_W'(-2);

  p_zero_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start && eff == '0) |=> (done && result == '0));

  p_rw_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  p_lane_after_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_we |-> $past(gate_pulse));

  p_cmd_after_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd |-> (fl_we && fl_wdata == 8'h40 && $past(lane_we)));

  p_tmo_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_poll_tmo |=> gate_pulse ##1 (fl_we && fl_wdata == 8'h50));

  p_budget_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_budget_out |=> (result == MINUS_TWO));

  p_mismatch_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mismatch |=> (result == '0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready);

endmodule

bind fbp_seq fbp_checker #(.EFF_W(EFF_W), .RES_W(RES_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ev_start     (ev_start),
  .eff          (eff_w),
  .ev_poll_tmo  (ev_poll_tmo),
  .ev_budget_out(ev_budget_out),
  .ev_mismatch  (ev_mismatch),
  .ev_cmd       (ev_cmd),
  .fl_we        (fl_we),
  .fl_re        (fl_re),
  .fl_wdata     (fl_wdata),
  .gate_pulse   (gate_pulse),
  .lane_we      (lane_we),
  .s_ready      (s_ready),
  .done         (done),
  .result       (result)
);

// File: tb/tb_fbp_seq.sv
`timescale 1ns/100ps
module tb_fbp_seq;
  localparam int ADDR_W = 20;
  localparam int CNT_W  = 18;
  localparam int BLK_W  = 16;
  localparam int POLL_L = 6;
  localparam int RES_W  = BLK_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic [CNT_W-1:0]  byte_cnt = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_ready;
  logic [ADDR_W-1:0] fl_addr;
  logic [7:0] fl_wdata;
  logic fl_we, fl_re;
  logic [7:0] rd_r = '0;
  logic gate_pulse, lane_we;
  logic [1:0] lane_sel;
  logic done;
  logic signed [RES_W-1:0] result;

  always #2.5 clk = ~clk;

  fbp_seq #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .BLK_W(BLK_W), .POLL_LIMIT(POLL_L),
    .RETRY_WAIT(5), .SETTLE_WAIT(4), .BUDGET_LIMIT(400)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
    .fl_rdata(rd_r), .gate_pulse(gate_pulse), .lane_we(lane_we),
    .lane_sel(lane_sel), .done(done), .result(result)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] mem_r [int];
  int stat_mode = 0, armed = 0, op_idx = 0, poll_n = 0;
  int cur_stall = 0, cur_err = 0;
  int stall_ops = 0, err_ops = 0, poll_delay = 2, flip_addr = -1;
  int writes = 0, clears = 0;
  logic [1:0] lane_r = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (lane_we) lane_r = lane_sel;
      if (fl_we) begin
        writes++;
        if (armed != 0) begin
          int a;
          logic [7:0] v;
          a = int'({fl_addr[ADDR_W-1:2], lane_r});
          v = fl_wdata;
          if (a == flip_addr) v = v ^ 8'h01;
          cur_stall = (op_idx < stall_ops) ? 1 : 0;
          cur_err   = (op_idx < err_ops) ? 1 : 0;
          if (cur_err == 0) mem_r[a] = v;
          op_idx++;
          poll_n = 0;
          armed = 0;
        end else begin
          case (fl_wdata)
            8'h40: armed = 1;
            8'h70: stat_mode = 1;
            8'hFF: stat_mode = 0;
            8'h50: clears++;
            default: ;
          endcase
        end
      end
      if (fl_re) begin
        if (stat_mode != 0) begin
          if (cur_stall != 0 || poll_n < poll_delay) rd_r = 8'h00;
          else rd_r = (cur_err != 0) ? 8'h90 : 8'h80;
          poll_n++;
        end else begin
          rd_r = mem_r.exists(int'(fl_addr)) ? mem_r[int'(fl_addr)] : 8'hFF;
        end
      end
    end
  end

  // ---------------- stream driver ----------------
  logic [7:0] beat_q[$];
  bit hs = 1'b0;

  always @(negedge clk) begin
    if (hs && beat_q.size() > 0) void'(beat_q.pop_front());
    s_valid = (beat_q.size() > 0);
    s_data  = s_valid ? beat_q[0] : 8'h00;
    hs      = s_valid && s_ready && rst_n;
  end

  // ---------------- scoreboard monitor ----------------
  logic signed [RES_W-1:0] exp_q[$];
  int done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "unexpected done", longint'(result), 0);
      end else begin
        logic signed [RES_W-1:0] e;
        e = exp_q.pop_front();
        chk(result == e, "R7", "result", longint'(result), longint'(e));
      end
      done_cnt++;
    end
  end

  // ---------------- driver ----------------
  logic [7:0] pq[$];
  logic [7:0] vq[$];

  task automatic make_data(input int n, input int seed);
    pq.delete();
    for (int i = 0; i < n; i++) pq.push_back(8'((seed * 37 + i * 91 + 5) & 255));
    vq = pq;
  endtask

  task automatic run(input int addr, input int cnt, input logic signed [RES_W-1:0] er,
                     input string req);
    int d0;
    op_idx = 0; writes = 0; clears = 0; armed = 0;
    foreach (pq[i]) beat_q.push_back(pq[i]);
    foreach (vq[i]) beat_q.push_back(vq[i]);
    exp_q.push_back(er);
    d0 = done_cnt;
    @(negedge clk);
    start = 1'b1;
    start_addr = ADDR_W'(addr);
    byte_cnt = CNT_W'(cnt);
    @(negedge clk);
    start = 1'b0;
    wait (done_cnt != d0);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done one cycle", longint'(done), 0);
    chk(beat_q.size() == 0, req, "beats left after done (R10)",
        longint'(beat_q.size()), 0);
    beat_q.delete();
  endtask

  task automatic check_mem(input int addr, input string req);
    foreach (pq[i]) begin
      int a;
      a = addr + i;
      chk(mem_r.exists(a) && mem_r[a] == pq[i], req, "programmed byte",
          mem_r.exists(a) ? longint'(mem_r[a]) : -1, longint'(pq[i]));
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(done == 1'b0 && s_ready == 1'b0, "R9", "reset done/ready",
        longint'({done, s_ready}), 0);
    chk(fl_we == 1'b0 && fl_re == 1'b0 && result == '0, "R3", "reset bus idle",
        longint'({fl_we, fl_re}), 0);

    // R1: zero count, done in the next cycle, no access
    writes = 0;
    exp_q.push_back('0);
    start = 1'b1; start_addr = ADDR_W'(32'h1_2345); byte_cnt = '0;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R1", "done one cycle after zero-count start", longint'(done), 1);
    @(negedge clk);
    chk(writes == 0, "R1", "flash writes for zero count", writes, 0);

    // R3/R7: basic run across word lanes
    make_data(4, 1);
    run(32'h2_0003, 4, RES_W'(4), "R7");
    check_mem(32'h2_0003, "R3");
    chk(op_idx == 4 && clears == 0, "R3", "program ops", op_idx, 4);

    // R2: trimmed at block end
    make_data(2, 2);
    run(32'h1_FFFE, 5, RES_W'(2), "R2");
    check_mem(32'h1_FFFE, "R2");
    chk(!mem_r.exists(32'h2_0000 + 100) && op_idx == 2, "R2", "ops after trim", op_idx, 2);

    // R2: oversized count trims to one byte
    make_data(1, 3);
    run(32'h4_FFFF, 32'h3_FFFF, RES_W'(1), "R2");
    check_mem(32'h4_FFFF, "R2");
    chk(!mem_r.exists(32'h5_0000), "R2", "byte beyond block untouched",
        longint'(mem_r.exists(32'h5_0000)), 0);

    // R2: run ending exactly on the boundary is not trimmed
    make_data(4, 4);
    run(32'h3_FFFC, 4, RES_W'(4), "R2");
    check_mem(32'h3_FFFC, "R2");

    // R4: status ready exactly at the poll limit is accepted
    poll_delay = POLL_L;
    make_data(3, 5);
    run(32'h6_0010, 3, RES_W'(3), "R4");
    chk(op_idx == 3 && clears == 0, "R4", "no retry at poll limit", clears, 0);
    poll_delay = 2;

    // R4: a stalled status forces one clear and immediate retry
    stall_ops = 1;
    make_data(3, 6);
    run(32'h6_0100, 3, RES_W'(3), "R4");
    chk(op_idx == 4, "R4", "ops with one timeout", op_idx, 4);
    chk(clears == 1, "R4", "clear writes with one timeout", clears, 1);
    check_mem(32'h6_0100, "R4");
    stall_ops = 0;

    // R5: two program failures retried after a wait
    err_ops = 2;
    make_data(3, 7);
    run(32'h6_0200, 3, RES_W'(3), "R5");
    chk(op_idx == 5 && clears == 2, "R5", "ops with two failures", op_idx, 5);
    check_mem(32'h6_0200, "R5");

    // R6/R10: persistent failure runs out the budget
    err_ops = 100000;
    make_data(4, 8);
    run(32'h6_0300, 4, RES_W'(-2), "R10");
    chk(op_idx >= 2, "R6", "several attempts before giving up", op_idx, 2);
    chk(!mem_r.exists(32'h6_0300), "R6", "failed byte not stored",
        longint'(mem_r.exists(32'h6_0300)), 0);
    err_ops = 0;

    // R8/R10: second presentation differs at byte 1
    make_data(4, 9);
    vq[1] = vq[1] ^ 8'h10;
    run(32'h7_0000, 4, RES_W'(0), "R8");
    check_mem(32'h7_0000, "R8");

    // R8: device corrupts one byte
    flip_addr = 32'h7_0102;
    make_data(3, 10);
    run(32'h7_0100, 3, RES_W'(0), "R8");
    flip_addr = -1;

    // R7: run after error cases still succeeds
    make_data(5, 11);
    run(32'h8_0007, 5, RES_W'(5), "R7");
    check_mem(32'h8_0007, "R7");

    chk(exp_q.size() == 0, "R9", "results still pending", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule